// File: doc/BRIEF.md
# Codec register configuration sequencer over I2C

This block configures an audio codec through a two-wire I2C bus. It holds several fixed lists of register writes and plays one list on each event it receives: a power-up request and a power-down request from the power manager, and the insertion or removal of a plug in the line-out jack. A volume request carries a 4-bit level. The block translates that level through one of two 16-entry tables and writes the result to both channel volume registers. The line-out plug state picks the table.

Each register write is a complete I2C write transaction to bus address byte 0x94. A read transaction of the same register follows at once, using a repeated start and address byte 0x95, and the byte read back is compared with the byte written. The power-up list starts with an address-only access that the codec is expected to refuse. The result of that access is ignored. A missing acknowledge anywhere else, or a read-back mismatch, stops the block for good. The block then closes the bus with a STOP where one is needed and holds an output high that lights sequencer LED 2 at full brightness. Only a reset clears this state.

Events that arrive while a list is running are held in a small queue and served in the order they arrived. The I2C side is a bit-level engine with open-drain outputs. Each output pulls its line low when high. SCL runs at CLK_HZ / (4 x QTR) with QTR = CLK_HZ / (4 x SCL_HZ).

Top module: `codec_cfg_seq`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, busy_o and halted_o are all 0. Whenever the block has no list running and nothing queued, it releases both bus lines.
- R2: A power-up request first performs START, address byte 0x94 and STOP, and ignores the acknowledge bit. It then writes, in this order: 05=A1, 06=27, 26=F0, 08=81, 09=81, 16=0C, 17=0C, 20=F0, 21=F0, 1F=8F, 1E=06, 04=0A.
- R3: Each register write is START, 0x94, register, data, STOP. It is followed at once by START, 0x94, register, repeated START, 0x95, one byte read with a not-acknowledge, and STOP. The register read back is always the register just written.
- R4: A power-down request writes 04=FF and then 02=9F.
- R5: A rising edge on lo_plug_i (1 = plug inserted) writes 0F=F2, then 04=AF, then 1F=80.
- R6: A falling edge on lo_plug_i writes 04=FF, then 1F=8F, then 04=FA.
- R7: With lo_plug_i low, a volume request with level L (0..15 stands for volume 1..16) writes the same code to register 20 and then register 21. The codes for L = 0..15 are 38 C4 D8 E8 F0 F4 F8 FC 00 04 08 0C 10 14 16 18.
- R8: With lo_plug_i high, the volume codes are 38 9C B0 C4 D8 E0 E8 F0 F8 FC 00 04 08 0C 10 18 instead.
- R9: A read-back byte that differs from the written byte sets halted_o. halted_o stays set until reset. No further register is written, both bus lines are released, and later requests have no effect.
- R10: A missing acknowledge on any byte other than the probe address sets halted_o and ends the transaction with a STOP. The data byte of that transaction is not written.
- R11: Requests that arrive while a list is running are served afterwards, in arrival order. At most one request is taken per cycle, with priority power-up, then power-down, then plug edge, then volume. The queue holds up to QDEPTH requests and drops requests beyond that.
- R12: SDA changes while SCL is released only for a START or a STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up_i | input | 1 | One-cycle power-up request |
| pwr_dn_i | input | 1 | One-cycle power-down request |
| lo_plug_i | input | 1 | Line-out plug present (1 = inserted) |
| vol_req_i | input | 1 | One-cycle volume request |
| vol_level_i | input | 4 | Volume level 0..15 (volume 1..16) |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | A list is running or requests are queued |
| halted_o | output | 1 | Configuration failed; drives LED 2 at full brightness |

## Verification
The bench places a codec model on the bus. The model logs every register written and every register read back. It can refuse the first address, refuse every address, or corrupt the read-back of one register. The probe refusal at power-up targets a design that treats it as a failure: that design would halt before writing anything. Corrupting register 16 targets a design that skips the compare or keeps going after a mismatch: it would write the registers after 16. Refusing every address targets a design that misses the acknowledge check: it would log writes even though no byte was acknowledged. Random volume levels against both tables, together with the extreme levels 0 and 15, catch a swapped or shifted table. A power-down request and a volume request issued during power-up catch requests that are lost or served out of order.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
    typedef enum logic [2:0] {K_PWRUP, K_PWRDN, K_OUTIN, K_OUTOUT, K_VOL} kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [3:0] lvl;
    } req_t;

    typedef enum logic [1:0] {E_START, E_WR, E_RD, E_STOP} ecmd_e;

    localparam logic [15:0] LIST_END = 16'hFFFF;
    localparam logic [7:0]  WR_ADDR  = 8'h94;
    localparam logic [7:0]  RD_ADDR  = 8'h95;
endpackage

// File: rtl/codec_cfg_rom.sv
module codec_cfg_rom
    import codec_cfg_pkg::*;
(
    input  kind_e       kind_i,
    input  logic [3:0]  idx_i,
    input  logic [7:0]  vol_code_i,
    output logic [15:0] word_o
);
    always_comb begin
        word_o = LIST_END;
        unique case (kind_i)
            K_PWRUP: case (idx_i)
                4'd0:  word_o = 16'h05A1;
                4'd1:  word_o = 16'h0627;
                4'd2:  word_o = 16'h26F0;
                4'd3:  word_o = 16'h0881;
                4'd4:  word_o = 16'h0981;
                4'd5:  word_o = 16'h160C;
                4'd6:  word_o = 16'h170C;
                4'd7:  word_o = 16'h20F0;
                4'd8:  word_o = 16'h21F0;
                4'd9:  word_o = 16'h1F8F;
                4'd10: word_o = 16'h1E06;
                4'd11: word_o = 16'h040A;
                default: word_o = LIST_END;
            endcase
            K_PWRDN: case (idx_i)
                4'd0: word_o = 16'h04FF;
                4'd1: word_o = 16'h029F;
                default: word_o = LIST_END;
            endcase
            K_OUTIN: case (idx_i)
                4'd0: word_o = 16'h0FF2;
                4'd1: word_o = 16'h04AF;
                4'd2: word_o = 16'h1F80;
                default: word_o = LIST_END;
            endcase
            K_OUTOUT: case (idx_i)
                4'd0: word_o = 16'h04FF;
                4'd1: word_o = 16'h1F8F;
                4'd2: word_o = 16'h04FA;
                default: word_o = LIST_END;
            endcase
            default: case (idx_i)
                4'd0: word_o = {8'h20, vol_code_i};
                4'd1: word_o = {8'h21, vol_code_i};
                default: word_o = LIST_END;
            endcase
        endcase
    end
endmodule

// File: rtl/codec_vol_map.sv
module codec_vol_map (
    input  logic [3:0] lvl_i,
    input  logic       line_i,
    output logic [7:0] code_o
);
    logic [7:0] spk, line;

    always_comb begin
        case (lvl_i)
            4'd0: spk = 8'h38;  4'd1: spk = 8'hC4;  4'd2: spk = 8'hD8;  4'd3: spk = 8'hE8;
            4'd4: spk = 8'hF0;  4'd5: spk = 8'hF4;  4'd6: spk = 8'hF8;  4'd7: spk = 8'hFC;
            4'd8: spk = 8'h00;  4'd9: spk = 8'h04;  4'd10: spk = 8'h08; 4'd11: spk = 8'h0C;
            4'd12: spk = 8'h10; 4'd13: spk = 8'h14; 4'd14: spk = 8'h16; default: spk = 8'h18;
        endcase
        case (lvl_i)
            4'd0: line = 8'h38;  4'd1: line = 8'h9C;  4'd2: line = 8'hB0;  4'd3: line = 8'hC4;
            4'd4: line = 8'hD8;  4'd5: line = 8'hE0;  4'd6: line = 8'hE8;  4'd7: line = 8'hF0;
            4'd8: line = 8'hF8;  4'd9: line = 8'hFC;  4'd10: line = 8'h00; 4'd11: line = 8'h04;
            4'd12: line = 8'h08; 4'd13: line = 8'h0C; 4'd14: line = 8'h10; default: line = 8'h18;
        endcase
        code_o = line_i ? line : spk;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import codec_cfg_pkg::*;
#(
    parameter int QTR = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  ecmd_e      cmd_i,
    input  logic [7:0] wdata_i,
    input  logic       sda_i,
    output logic       idle_o,
    output logic       done_o,
    output logic       ack_o,
    output logic [7:0] rdata_o,
    output logic       scl_low_o,
    output logic       sda_low_o
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    typedef enum logic [1:0] {B_IDLE, B_START, B_BYTE, B_STOP} bst_e;

    typedef struct packed {
        bst_e          st;
        logic [1:0]    qp;
        logic [3:0]    bitn;
        logic [CW-1:0] cnt;
        logic [7:0]    sh;
        logic          rd;
        logic          scl_low;
        logic          sda_low;
        logic          ack;
        logic          done;
    } eng_t;

    eng_t q_q, d_d;
    logic tick;

    always_comb begin
        d_d      = q_q;
        d_d.done = 1'b0;
        tick     = (q_q.cnt == CW'(QTR - 1));
        if (q_q.st != B_IDLE) begin
            d_d.cnt = tick ? '0 : q_q.cnt + CW'(1);
            if (tick) d_d.qp = q_q.qp + 2'd1;
        end
        case (q_q.st)
            B_IDLE: if (cmd_valid_i) begin
                d_d.cnt  = '0;
                d_d.qp   = 2'd0;
                d_d.bitn = 4'd0;
                d_d.rd   = (cmd_i == E_RD);
                d_d.sh   = (cmd_i == E_WR) ? wdata_i : 8'h00;
                case (cmd_i)
                    E_START: d_d.st = B_START;
                    E_STOP:  d_d.st = B_STOP;
                    default: d_d.st = B_BYTE;
                endcase
            end
            B_START: if (tick) case (q_q.qp)
                2'd0: d_d.sda_low = 1'b0;
                2'd1: d_d.scl_low = 1'b0;
                2'd2: d_d.sda_low = 1'b1;
                default: begin d_d.scl_low = 1'b1; d_d.st = B_IDLE; d_d.done = 1'b1; end
            endcase
            B_BYTE: if (tick) case (q_q.qp)
                2'd0: d_d.sda_low = (!q_q.rd && q_q.bitn < 4'd8) ? !q_q.sh[7] : 1'b0;
                2'd1: d_d.scl_low = 1'b0;
                2'd2: if (q_q.bitn < 4'd8) d_d.sh = {q_q.sh[6:0], sda_i};
                      else d_d.ack = !sda_i;
                default: begin
                    d_d.scl_low = 1'b1;
                    if (q_q.bitn == 4'd8) begin d_d.st = B_IDLE; d_d.done = 1'b1; end
                    else d_d.bitn = q_q.bitn + 4'd1;
                end
            endcase
            default: if (tick) case (q_q.qp)
                2'd0: d_d.sda_low = 1'b1;
                2'd1: d_d.scl_low = 1'b0;
                2'd2: d_d.sda_low = 1'b0;
                default: begin d_d.st = B_IDLE; d_d.done = 1'b1; end
            endcase
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '{st: B_IDLE, default: '0};
        else        q_q <= d_d;
    end

    assign idle_o    = (q_q.st == B_IDLE);
    assign done_o    = q_q.done;
    assign ack_o     = q_q.ack;
    assign rdata_o   = q_q.sh;
    assign scl_low_o = q_q.scl_low;
    assign sda_low_o = q_q.sda_low;

    // R12: with SCL released on both sides, an SDA change comes only from a START or a STOP
    assert_sda_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_q.scl_low && !$past(q_q.scl_low) && (q_q.sda_low != $past(q_q.sda_low)))
        |-> ($past(q_q.st) == B_START || $past(q_q.st) == B_STOP));

    // R3: a new operation is only issued to an idle engine
    assert_cmd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |-> (q_q.st == B_IDLE));
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
    import codec_cfg_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int SCL_HZ = 100_000,
    parameter int QDEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up_i,
    input  logic       pwr_dn_i,
    input  logic       lo_plug_i,
    input  logic       vol_req_i,
    input  logic [3:0] vol_level_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       busy_o,
    output logic       halted_o
);
    localparam int QTR = CLK_HZ / (4 * SCL_HZ);
    localparam int PW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CNW = $clog2(QDEPTH + 1);

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_FSTOP, S_FWAIT, S_HALT} sst_e;

    typedef struct packed {
        sst_e                   sst;
        kind_e                  kind;
        logic [3:0]             lvl;
        logic [3:0]             idx;
        logic [3:0]             step;
        logic [7:0]             rg;
        logic [7:0]             dat;
        logic [7:0]             rbk;
        logic                   halted;
        logic                   plug;
        req_t [QDEPTH-1:0]      fifo;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [CNW-1:0]         cnt;
    } seq_t;

    seq_t q_q, d_d;

    logic        eng_idle, eng_done, eng_ack, cmd_v;
    logic [7:0]  eng_rdata, vol_code, cmd_wd, step_wd;
    logic [15:0] word;
    ecmd_e       cmd, step_cmd;
    logic        step_ack, push_v, push_ok, pop;
    req_t        push_r, head;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(QDEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    codec_vol_map u_vol (.lvl_i(q_q.lvl), .line_i(q_q.plug), .code_o(vol_code));
    codec_cfg_rom u_rom (.kind_i(q_q.kind), .idx_i(q_q.idx), .vol_code_i(vol_code), .word_o(word));

    i2c_byte_engine #(.QTR(QTR)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_v), .cmd_i(cmd), .wdata_i(cmd_wd),
        .sda_i(sda_i), .idle_o(eng_idle), .done_o(eng_done), .ack_o(eng_ack),
        .rdata_o(eng_rdata), .scl_low_o(scl_oe_o), .sda_low_o(sda_oe_o)
    );

    // Transaction micro-steps: 0-4 write, 5-11 read-back, 12-14 probe
    always_comb begin
        step_cmd = E_STOP; step_wd = 8'h00; step_ack = 1'b0;
        case (q_q.step)
            4'd0, 4'd5, 4'd8, 4'd12: step_cmd = E_START;
            4'd1, 4'd6: begin step_cmd = E_WR; step_wd = WR_ADDR; step_ack = 1'b1; end
            4'd2, 4'd7: begin step_cmd = E_WR; step_wd = q_q.rg;  step_ack = 1'b1; end
            4'd3:       begin step_cmd = E_WR; step_wd = q_q.dat; step_ack = 1'b1; end
            4'd9:       begin step_cmd = E_WR; step_wd = RD_ADDR; step_ack = 1'b1; end
            4'd10:      step_cmd = E_RD;
            4'd13:      begin step_cmd = E_WR; step_wd = WR_ADDR; end
            default:    step_cmd = E_STOP;
        endcase
    end

    always_comb begin
        d_d = q_q;
        d_d.plug = lo_plug_i;
        cmd_v = 1'b0; cmd = step_cmd; cmd_wd = step_wd;
        push_v = 1'b0; push_r = '0; head = q_q.fifo[q_q.rp];
        if (q_q.sst != S_HALT) begin
            if (pwr_up_i)                    begin push_v = 1'b1; push_r.kind = K_PWRUP;  end
            else if (pwr_dn_i)               begin push_v = 1'b1; push_r.kind = K_PWRDN;  end
            else if (lo_plug_i && !q_q.plug) begin push_v = 1'b1; push_r.kind = K_OUTIN;  end
            else if (!lo_plug_i && q_q.plug) begin push_v = 1'b1; push_r.kind = K_OUTOUT; end
            else if (vol_req_i) begin push_v = 1'b1; push_r.kind = K_VOL; push_r.lvl = vol_level_i; end
        end
        push_ok = push_v && (q_q.cnt < CNW'(QDEPTH));
        pop     = (q_q.sst == S_IDLE) && (q_q.cnt != '0);
        if (push_ok) begin d_d.fifo[q_q.wp] = push_r; d_d.wp = nxt(q_q.wp); end
        d_d.cnt = q_q.cnt + CNW'(push_ok) - CNW'(pop);

        case (q_q.sst)
            S_IDLE: if (pop) begin
                d_d.rp = nxt(q_q.rp); d_d.kind = head.kind; d_d.lvl = head.lvl; d_d.idx = 4'd0;
                if (head.kind == K_PWRUP) begin d_d.step = 4'd12; d_d.sst = S_ISSUE; end
                else d_d.sst = S_FETCH;
            end
            S_FETCH: if (word == LIST_END) d_d.sst = S_IDLE;
                     else begin
                         d_d.rg = word[15:8]; d_d.dat = word[7:0];
                         d_d.step = 4'd0; d_d.sst = S_ISSUE;
                     end
            S_ISSUE: if (eng_idle) begin cmd_v = 1'b1; d_d.sst = S_WAIT; end
            S_WAIT: if (eng_done) begin
                if (step_ack && !eng_ack) begin d_d.halted = 1'b1; d_d.sst = S_FSTOP; end
                else if (q_q.step == 4'd11) begin
                    if (q_q.rbk != q_q.dat) begin d_d.halted = 1'b1; d_d.sst = S_HALT; end
                    else begin d_d.idx = q_q.idx + 4'd1; d_d.sst = S_FETCH; end
                end else if (q_q.step == 4'd14) d_d.sst = S_FETCH;
                else begin
                    if (q_q.step == 4'd10) d_d.rbk = eng_rdata;
                    d_d.step = q_q.step + 4'd1; d_d.sst = S_ISSUE;
                end
            end
            S_FSTOP: if (eng_idle) begin cmd_v = 1'b1; cmd = E_STOP; d_d.sst = S_FWAIT; end
            S_FWAIT: if (eng_done) d_d.sst = S_HALT;
            default: d_d.sst = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '{sst: S_IDLE, kind: K_PWRUP, default: '0};
        else        q_q <= d_d;
    end

    assign busy_o   = ((q_q.sst != S_IDLE) && (q_q.sst != S_HALT)) || (q_q.cnt != '0);
    assign halted_o = q_q.halted;

    assert_bus_free_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.sst == S_IDLE) |-> (!scl_oe_o && !sda_oe_o));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    assert_halt_bus_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.sst == S_HALT) |-> (!scl_oe_o && !sda_oe_o && eng_idle));

    // R11: the queue never reports more entries than it has slots
    assert_queue_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.cnt == CNW'(QDEPTH)) |=> (q_q.cnt <= CNW'(QDEPTH)));
endmodule

// File: tb/tb_codec_cfg_seq.sv
module tb_codec_cfg_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_up = 1'b0, pwr_dn = 1'b0, lo_plug = 1'b0, vol_req = 1'b0;
    logic [3:0] vol_lvl = 4'd0;
    logic       scl_oe, sda_oe, busy, halted;
    logic       s_sda_low = 1'b0;
    wire        scl = ~scl_oe;
    wire        sda_line = ~(sda_oe | s_sda_low);

    always #5 clk = ~clk;

    codec_cfg_seq #(.CLK_HZ(800_000), .SCL_HZ(100_000), .QDEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_up_i(pwr_up), .pwr_dn_i(pwr_dn), .lo_plug_i(lo_plug),
        .vol_req_i(vol_req), .vol_level_i(vol_lvl), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .halted_o(halted)
    );

    int checks = 0, fails = 0;

    // ---- codec model ----
    bit nak_first_req = 1'b0, nak_all = 1'b0;
    int corrupt_reg = -1;
    logic [7:0] regs [0:255];
    logic [7:0] wr_reg [0:255];
    logic [7:0] wr_val [0:255];
    logic [7:0] rd_reg [0:255];
    int nwr = 0, nrd = 0, addr_seen = 0;
    int s_mode = 0, bcnt = 0, byte_no = 0, tcnt = 0;
    bit reading = 1'b0, acked = 1'b0, ack = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1, cur_sda = 1'b1;
    logic [7:0] sh = 8'h00, ptr = 8'h00, txb = 8'h00;

    always @(negedge clk) begin
        cur_sda = sda_line;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] = 8'h00;
            nwr = 0; nrd = 0; addr_seen = 0; s_mode = 0; s_sda_low = 1'b0;
        end else if (prev_scl && scl && prev_sda && !cur_sda) begin
            s_mode = 1; bcnt = 0; byte_no = 0; s_sda_low = 1'b0;
        end else if (prev_scl && scl && !prev_sda && cur_sda) begin
            s_mode = 0; s_sda_low = 1'b0;
        end else if (!prev_scl && scl) begin
            if (s_mode == 1 && bcnt < 8) begin sh = {sh[6:0], cur_sda}; bcnt++; end
        end else if (prev_scl && !scl) begin
            if (s_mode == 1 && bcnt == 8) begin
                ack = 1'b1;
                if (byte_no == 0) begin
                    if (nak_all || (nak_first_req && addr_seen == 0) || (sh != 8'h94 && sh != 8'h95)) ack = 1'b0;
                    addr_seen++;
                    reading = (sh == 8'h95);
                    if (reading && ack && nrd < 256) begin rd_reg[nrd] = ptr; nrd++; end
                end else if (byte_no == 1) ptr = sh;
                else if (byte_no == 2 && nwr < 256) begin
                    regs[ptr] = sh; wr_reg[nwr] = ptr; wr_val[nwr] = sh; nwr++;
                end
                s_sda_low = ack; acked = ack; bcnt = 9; byte_no++;
            end else if (s_mode == 1 && bcnt == 9) begin
                s_sda_low = 1'b0; bcnt = 0;
                if (!acked) s_mode = 0;
                else if (reading) begin
                    s_mode = 2; tcnt = 0;
                    txb = regs[ptr] ^ ((int'(ptr) == corrupt_reg) ? 8'h01 : 8'h00);
                    s_sda_low = !txb[7];
                end
            end else if (s_mode == 2) begin
                if (tcnt < 7) begin tcnt++; s_sda_low = !txb[7 - tcnt]; end
                else begin s_sda_low = 1'b0; s_mode = 0; end
            end
        end
        prev_scl = scl; prev_sda = cur_sda;
    end

    // ---- expected model ----
    logic [7:0] ex_reg [0:255];
    logic [7:0] ex_val [0:255];
    int nex = 0, seen = 0;

    function automatic logic [7:0] spk_code(input int l);
        case (l)
            0: return 8'h38; 1: return 8'hC4; 2: return 8'hD8; 3: return 8'hE8;
            4: return 8'hF0; 5: return 8'hF4; 6: return 8'hF8; 7: return 8'hFC;
            8: return 8'h00; 9: return 8'h04; 10: return 8'h08; 11: return 8'h0C;
            12: return 8'h10; 13: return 8'h14; 14: return 8'h16; default: return 8'h18;
        endcase
    endfunction

    function automatic logic [7:0] line_code(input int l);
        case (l)
            0: return 8'h38; 1: return 8'h9C; 2: return 8'hB0; 3: return 8'hC4;
            4: return 8'hD8; 5: return 8'hE0; 6: return 8'hE8; 7: return 8'hF0;
            8: return 8'hF8; 9: return 8'hFC; 10: return 8'h00; 11: return 8'h04;
            12: return 8'h08; 13: return 8'h0C; 14: return 8'h10; default: return 8'h18;
        endcase
    endfunction

    task automatic ex(input logic [15:0] w);
        ex_reg[nex] = w[15:8]; ex_val[nex] = w[7:0]; nex++;
    endtask

    task automatic ex_pwrup(input int upto);
        logic [15:0] l [0:11];
        l = '{16'h05A1, 16'h0627, 16'h26F0, 16'h0881, 16'h0981, 16'h160C,
              16'h170C, 16'h20F0, 16'h21F0, 16'h1F8F, 16'h1E06, 16'h040A};
        for (int i = 0; i < upto; i++) ex(l[i]);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cmp_logs(input string req);
        chk(nwr == nex, req, nwr, nex);
        chk(nrd == nwr, "R3 read-back count", nrd, nwr);
        for (int i = seen; i < nex && i < nwr; i++) begin
            chk({wr_reg[i], wr_val[i]} == {ex_reg[i], ex_val[i]}, req,
                {wr_reg[i], wr_val[i]}, {ex_reg[i], ex_val[i]});
            chk(i < nrd && rd_reg[i] == wr_reg[i], "R3 read-back register", rd_reg[i], wr_reg[i]);
        end
        seen = nex;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int which, input int lvl);
        @(negedge clk);
        case (which)
            0: pwr_up = 1'b1;
            1: pwr_dn = 1'b1;
            default: begin vol_req = 1'b1; vol_lvl = 4'(lvl); end
        endcase
        @(negedge clk);
        pwr_up = 1'b0; pwr_dn = 1'b0; vol_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwr_up = 1'b0; pwr_dn = 1'b0; vol_req = 1'b0; lo_plug = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; nex = 0; seen = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int lvl;
        void'($urandom(32'd1234));
        do_reset();
        // R1 reset state
        chk(!scl_oe, "R1 scl", scl_oe, 0);
        chk(!sda_oe, "R1 sda", sda_oe, 0);
        chk(!busy, "R1 busy", busy, 0);
        chk(!halted, "R1 halted", halted, 0);

        // R2 power-up with probe refused by the codec
        nak_first_req = 1'b1;
        pulse(0, 0); wait_idle();
        nak_first_req = 1'b0;
        chk(!halted, "R2 probe NAK not a failure", halted, 0);
        ex_pwrup(12); cmp_logs("R2 power-up list");
        chk(!scl_oe && !sda_oe, "R1 bus released when idle", {scl_oe, sda_oe}, 0);

        // R4
        pulse(1, 0); wait_idle();
        ex(16'h04FF); ex(16'h029F); cmp_logs("R4 power-down list");

        // R5 then R8 random and corner levels on line table
        @(negedge clk); lo_plug = 1'b1; wait_idle();
        ex(16'h0FF2); ex(16'h04AF); ex(16'h1F80); cmp_logs("R5 out-inserted list");
        for (int i = 0; i < 6; i++) begin
            lvl = (i == 0) ? 0 : (i == 1) ? 15 : int'($urandom_range(15, 0));
            pulse(2, lvl); wait_idle();
            ex({8'h20, line_code(lvl)}); ex({8'h21, line_code(lvl)});
            cmp_logs("R8 line-out volume");
        end

        // R6 then R7
        @(negedge clk); lo_plug = 1'b0; wait_idle();
        ex(16'h04FF); ex(16'h1F8F); ex(16'h04FA); cmp_logs("R6 out-removed list");
        for (int i = 0; i < 6; i++) begin
            lvl = (i == 0) ? 15 : (i == 1) ? 0 : int'($urandom_range(15, 0));
            pulse(2, lvl); wait_idle();
            ex({8'h20, spk_code(lvl)}); ex({8'h21, spk_code(lvl)});
            cmp_logs("R7 speaker volume");
        end

        // R11 queued requests served in arrival order
        pulse(0, 0);
        repeat (50) @(negedge clk);
        pulse(1, 0);
        repeat (3) @(negedge clk);
        pulse(2, 9);
        wait_idle();
        ex_pwrup(12); ex(16'h04FF); ex(16'h029F); ex({8'h20, spk_code(9)}); ex({8'h21, spk_code(9)});
        cmp_logs("R11 queue order");
        chk(!halted, "R11 no halt", halted, 0);

        // R9 read-back mismatch on register 16
        do_reset();
        corrupt_reg = 8'h16;
        pulse(0, 0); wait_idle();
        ex_pwrup(6); cmp_logs("R9 writes stop at mismatch");
        chk(halted, "R9 halted", halted, 1);
        chk(!scl_oe && !sda_oe, "R9 bus released", {scl_oe, sda_oe}, 0);
        pulse(2, 3); wait_idle();
        chk(nwr == 6, "R9 later request ignored", nwr, 6);
        chk(halted && !busy, "R9 stays halted", {halted, busy}, 2);
        corrupt_reg = -1;

        // R10 missing acknowledge
        do_reset();
        nak_all = 1'b1;
        pulse(1, 0); wait_idle();
        chk(halted, "R10 halted on NAK", halted, 1);
        chk(nwr == 0, "R10 nothing written", nwr, 0);
        chk(!scl_oe && !sda_oe, "R10 bus released after STOP", {scl_oe, sda_oe}, 0);
        nak_all = 1'b0;

        // recovery by reset
        do_reset();
        chk(!halted && !busy, "R1 reset clears halt", {halted, busy}, 0);
        summary();
    end
endmodule